// File: doc/BRIEF.md
# APB Register Bank with Per-Register Access Modes

This block is a small memory-mapped register bank reached through an APB slave port with 32-bit data and byte addresses. It holds a fixed set of registers. Each register has one software access mode: read-write, read-only (driven live by hardware), constant, or write-only. Each register has a reset value built from its field presets. Two of the registers are 64 bits wide and take two consecutive word addresses. The parameter `WORD_ORDER` sets which half sits at the lower address (0: low half first, 1: high half first). A value of 2 forbids multi-word registers, and only the low word of each wide register stays addressable.

The hardware side receives the stored values of the writable registers as outputs: a control word, a command word, a key word and a 64-bit limit. It supplies a 32-bit status word and a 64-bit counter, which software can only read. The status word and the write-only command word share one address: a read returns status and a write loads command. Every access finishes in the first access-phase cycle. Refused or unmapped accesses are flagged with PSLVERR.

Map (byte addresses, bits numbered from bit 0 as LSB): 0x00 control (rw); 0x04 identity (cst); 0x08 status (ro) shared with command (wo); 0x0C key (wo); 0x10/0x14 limit (rw, 64-bit); 0x18/0x1C counter (ro, 64-bit). Everything from 0x20 up is unmapped.

Top module: `apb_regbank`

## Requirements
- R1: After reset, control reads 0x00C8_0051 (enable bit 0 = 1, mode bits 7:4 = 5, threshold bits 31:16 = 0x00C8), command and key are 0, and limit is 0x0000_0010_FFFF_0000.
- R2: A full-strobe write to control updates `cfg_ctrl` at the clock edge that ends the access phase, and a later read returns the written value.
- R3: A read of the identity word returns `ID_VALUE`; a write to it raises PSLVERR and changes nothing.
- R4: A read of a counter word returns the current `hw_count` half without error; a write to either counter word raises PSLVERR and changes nothing.
- R5: At 0x08, a read returns `hw_status` and a full-strobe write loads `cfg_cmd`; neither raises PSLVERR.
- R6: A read of the key word returns zero without PSLVERR; a full-strobe write loads `cfg_key`.
- R7: For 64-bit registers with WORD_ORDER 0, the low half is at the base address and the high half at base+4; with 1 the order is reversed; with 2 only the low half is reachable, at the base, and base+4 is unmapped.
- R8: A write to one half of the limit register updates that half of `cfg_limit` at once and leaves the other half unchanged.
- R9: A write whose PSTRB is not 4'b1111 raises PSLVERR and changes no register, at any address.
- R10: An access to an unmapped address completes with PREADY high, PSLVERR high and PRDATA zero.
- R11: PREADY is always high, and outside the access phase PSLVERR and PRDATA are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address; bits 1:0 ignored |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Write byte strobes |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete |
| pslverr | output | 1 | Error response |
| hw_status | input | 32 | Live status word |
| hw_count | input | 64 | Live 64-bit counter |
| cfg_ctrl | output | 32 | Stored control word |
| cfg_cmd | output | 32 | Stored command word |
| cfg_key | output | 32 | Stored key word |
| cfg_limit | output | 64 | Stored 64-bit limit |

## Verification
Word order only shows up when the same stimulus reaches banks built with different settings. The bench therefore drives one APB bus into three instances, one for each `WORD_ORDER` value, and checks each instance against its own model of which half every address reaches. The shared status/command address is hard to observe because a write to it is invisible through a read. The bench checks `cfg_cmd` right after each write and checks reads against a changing `hw_status`. Refused writes are swept over every partial strobe pattern, and every output is checked to be unchanged after each one.

// File: rtl/apb_regbank.sv
module apb_regbank #(
  parameter int          ADDR_W     = 6,
  parameter int          WORD_ORDER = 0,
  parameter logic [31:0] ID_VALUE   = 32'hB0A7_0102
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  input  logic [3:0]        pstrb,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [31:0]       hw_status,
  input  logic [63:0]       hw_count,
  output logic [31:0]       cfg_ctrl,
  output logic [31:0]       cfg_cmd,
  output logic [31:0]       cfg_key,
  output logic [63:0]       cfg_limit
);
  localparam int          IW           = ADDR_W - 2;
  localparam logic [31:0] CTRL_PRESET  = {16'h00C8, 8'h00, 4'h5, 3'b000, 1'b1};
  localparam logic [31:0] CMD_PRESET   = 32'h0;
  localparam logic [31:0] KEY_PRESET   = 32'h0;
  localparam logic [63:0] LIMIT_PRESET = {32'h0000_0010, 32'hFFFF_0000};
  localparam bit          WIDE_OK      = (WORD_ORDER != 2);

  logic [31:0] ctrl_q, cmd_q, key_q;
  logic [63:0] limit_q;
  logic [31:0] rd;

  wire          access    = psel & penable;
  wire [IW-1:0] widx      = paddr[ADDR_W-1:2];
  wire          hi_half   = (WORD_ORDER == 1) ? ~paddr[2] : paddr[2];
  wire          full_strb = &pstrb;

  wire hit_ctrl = (widx == IW'(0));
  wire hit_id   = (widx == IW'(1));
  wire hit_sc   = (widx == IW'(2));
  wire hit_key  = (widx == IW'(3));
  wire hit_lim  = (widx == IW'(4)) | ((widx == IW'(5)) & WIDE_OK);
  wire hit_cnt  = (widx == IW'(6)) | ((widx == IW'(7)) & WIDE_OK);
  wire mapped   = hit_ctrl | hit_id | hit_sc | hit_key | hit_lim | hit_cnt;

  wire wr_ok    = access & pwrite & full_strb;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ctrl_q  <= CTRL_PRESET;
      cmd_q   <= CMD_PRESET;
      key_q   <= KEY_PRESET;
      limit_q <= LIMIT_PRESET;
    end else if (wr_ok) begin
      if (hit_ctrl) ctrl_q <= pwdata;
      if (hit_sc)   cmd_q  <= pwdata;
      if (hit_key)  key_q  <= pwdata;
      if (hit_lim && hi_half)  limit_q[63:32] <= pwdata;
      if (hit_lim && !hi_half) limit_q[31:0]  <= pwdata;
    end
  end

  always_comb begin
    rd = '0;
    if (access && !pwrite) begin
      if (hit_ctrl)     rd = ctrl_q;
      else if (hit_id)  rd = ID_VALUE;
      else if (hit_sc)  rd = hw_status;
      else if (hit_lim) rd = hi_half ? limit_q[63:32] : limit_q[31:0];
      else if (hit_cnt) rd = hi_half ? hw_count[63:32] : hw_count[31:0];
    end
  end

  assign prdata    = rd;
  assign pready    = 1'b1;
  assign pslverr   = access & (~mapped | (pwrite & (~full_strb | hit_id | hit_cnt)));
  assign cfg_ctrl  = ctrl_q;
  assign cfg_cmd   = cmd_q;
  assign cfg_key   = key_q;
  assign cfg_limit = limit_q;

  AST_STRB_REFUSED: assert property (@(posedge pclk) disable iff (!presetn)
    (access && pwrite && !full_strb) |=> ($stable(ctrl_q) && $stable(cmd_q) && $stable(key_q) && $stable(limit_q))) else $error("partial strobe changed state"); // R9
  AST_CTRL_LOADS: assert property (@(posedge pclk) disable iff (!presetn)
    (access && pwrite && full_strb && widx == IW'(0)) |=> (cfg_ctrl == $past(pwdata))) else $error("control not loaded"); // R2
  AST_HALF_KEEPS: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_ok && hit_lim) |=> (hi_half ? $stable(limit_q[31:0]) : $stable(limit_q[63:32]))) else $error("other limit half moved"); // R8
  AST_RO_WRITE_REFUSED: assert property (@(posedge pclk) disable iff (!presetn)
    (access && pwrite && (hit_id || hit_cnt)) |=> ($stable(ctrl_q) && $stable(cmd_q) && $stable(key_q) && $stable(limit_q))) else $error("read-only write changed state"); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
    (access && !mapped) |-> (pslverr && prdata == 32'h0 && pready)) else $error("unmapped response wrong"); // R10
  AST_IDLE_QUIET: assert property (@(posedge pclk) disable iff (!presetn)
    !access |-> (!pslverr && prdata == 32'h0)) else $error("response outside access phase"); // R11
endmodule

// File: tb/apb_regbank_bench.sv
module apb_regbank_bench;
  localparam logic [31:0] IDV = 32'hB0A7_0102;

  logic clk = 1'b0;
  logic presetn = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [5:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [3:0] pstrb = '0;
  logic [31:0] hw_status = 32'h1234_5678;
  logic [63:0] hw_count = 64'hAAAA_0001_5555_0002;

  logic [31:0] prd [3];
  logic        prdy [3];
  logic        perr [3];
  logic [31:0] o_ctrl [3];
  logic [31:0] o_cmd [3];
  logic [31:0] o_key [3];
  logic [63:0] o_lim [3];

  int checks = 0, fails = 0;
  logic [31:0] m_ctrl, m_cmd, m_key;
  logic [63:0] m_lim [3];
  logic [31:0] got_rd [3];
  logic        got_err [3];
  logic        setup_err [3];

  always #10 clk = ~clk;

  apb_regbank #(.ADDR_W(6), .WORD_ORDER(0), .ID_VALUE(IDV)) u_apb_regbank (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prd[0]), .pready(prdy[0]),
    .pslverr(perr[0]), .hw_status(hw_status), .hw_count(hw_count), .cfg_ctrl(o_ctrl[0]),
    .cfg_cmd(o_cmd[0]), .cfg_key(o_key[0]), .cfg_limit(o_lim[0]));
  apb_regbank #(.ADDR_W(6), .WORD_ORDER(1), .ID_VALUE(IDV)) u_apb_regbank_be (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prd[1]), .pready(prdy[1]),
    .pslverr(perr[1]), .hw_status(hw_status), .hw_count(hw_count), .cfg_ctrl(o_ctrl[1]),
    .cfg_cmd(o_cmd[1]), .cfg_key(o_key[1]), .cfg_limit(o_lim[1]));
  apb_regbank #(.ADDR_W(6), .WORD_ORDER(2), .ID_VALUE(IDV)) u_apb_regbank_nw (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prd[2]), .pready(prdy[2]),
    .pslverr(perr[2]), .hw_status(hw_status), .hw_count(hw_count), .cfg_ctrl(o_ctrl[2]),
    .cfg_cmd(o_cmd[2]), .cfg_key(o_key[2]), .cfg_limit(o_lim[2]));

  task automatic check(input string tag, input string what, input int k,
                       input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s inst%0d: got %h expected %h", tag, what, k, got, exp);
    end
  endtask

  function automatic string tag_of(input logic wr, input logic [5:0] a, input logic [3:0] s);
    int w = int'(a[5:2]);
    if (wr && s != 4'hF) return "R9";
    case (w)
      0: return "R2";
      1: return "R3";
      2: return "R5";
      3: return "R6";
      4, 5: return wr ? "R8" : "R7";
      6, 7: return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic predict(input int k, input logic wr, input logic [5:0] a, input logic [31:0] d,
                         input logic [3:0] s, output logic [31:0] er, output logic ee);
    int w = int'(a[5:2]);
    logic hi = (k == 1) ? ~a[2] : a[2];
    er = '0; ee = 1'b0;
    if (wr && s != 4'hF) begin ee = 1'b1; return; end
    case (w)
      0: if (wr) m_ctrl = d; else er = m_ctrl;
      1: if (wr) ee = 1'b1; else er = IDV;
      2: if (wr) m_cmd = d; else er = hw_status;
      3: if (wr) m_key = d;
      4, 5: begin
        if (k == 2 && w == 5) ee = 1'b1;
        else if (wr) begin
          if (hi) m_lim[k][63:32] = d; else m_lim[k][31:0] = d;
        end else er = hi ? m_lim[k][63:32] : m_lim[k][31:0];
      end
      6, 7: begin
        if (k == 2 && w == 7) ee = 1'b1;
        else if (wr) ee = 1'b1;
        else er = hi ? hw_count[63:32] : hw_count[31:0];
      end
      default: ee = 1'b1;
    endcase
  endtask

  task automatic check_outputs(input string tag);
    for (int k = 0; k < 3; k++) begin
      check(tag, "cfg_ctrl", k, 64'(o_ctrl[k]), 64'(m_ctrl));
      check(tag, "cfg_cmd", k, 64'(o_cmd[k]), 64'(m_cmd));
      check(tag, "cfg_key", k, 64'(o_key[k]), 64'(m_key));
      check(tag, "cfg_limit", k, o_lim[k], m_lim[k]);
    end
  endtask

  task automatic xact(input logic wr, input logic [5:0] a, input logic [31:0] d, input logic [3:0] s);
    logic [31:0] er [3];
    logic        ee [3];
    string tag = tag_of(wr, a, s);
    for (int k = 0; k < 3; k++) predict(k, wr, a, d, s, er[k], ee[k]);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; pstrb = wr ? s : 4'h0;
    #1;
    for (int k = 0; k < 3; k++) setup_err[k] = perr[k];
    @(negedge clk);
    penable = 1'b1;
    #1;
    for (int k = 0; k < 3; k++) begin
      got_rd[k] = prd[k]; got_err[k] = perr[k];
      check("R11", "pready", k, 64'(prdy[k]), 64'd1);
      check("R11", "setup pslverr", k, 64'(setup_err[k]), 64'd0);
      check(tag, "pslverr", k, 64'(got_err[k]), 64'(ee[k]));
      if (!wr) check(tag, "prdata", k, 64'(got_rd[k]), 64'(er[k]));
    end
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
    #1;
    check_outputs(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    m_ctrl = 32'h00C8_0051; m_cmd = '0; m_key = '0;
    for (int k = 0; k < 3; k++) m_lim[k] = 64'h0000_0010_FFFF_0000;
    repeat (3) @(negedge clk);
    presetn = 1'b1;
    #1;
    check_outputs("R1");
    for (int k = 0; k < 3; k++) check("R11", "idle prdata", k, 64'(prd[k]), 64'd0);

    for (int a = 0; a < 64; a += 4) xact(1'b0, 6'(a), '0, '0);
    for (int a = 0; a < 64; a += 4) xact(1'b0, 6'(a + 1), '0, '0);

    for (int i = 0; i < 32; i++) begin
      xact(1'b1, 6'h00, 32'h1 << i, 4'hF);
      xact(1'b0, 6'h00, '0, '0);
    end
    xact(1'b1, 6'h00, 32'hC3A5_5A3C, 4'hF);

    xact(1'b1, 6'h04, 32'hDEAD_BEEF, 4'hF);
    xact(1'b0, 6'h04, '0, '0);

    for (int i = 0; i < 8; i++) begin
      hw_status = 32'h9E37_79B9 * (i + 1);
      hw_count  = {32'h0F0F_0000 + 32'(i), 32'h7000_0000 ^ (32'h1 << (4 * i))};
      xact(1'b0, 6'h08, '0, '0);
      xact(1'b0, 6'h18, '0, '0);
      xact(1'b0, 6'h1C, '0, '0);
    end
    xact(1'b1, 6'h18, 32'h1111_1111, 4'hF);
    xact(1'b1, 6'h1C, 32'h2222_2222, 4'hF);

    for (int i = 0; i < 4; i++) begin
      xact(1'b1, 6'h08, 32'h5000_0000 + 32'(i * 7), 4'hF);
      xact(1'b0, 6'h08, '0, '0);
    end

    xact(1'b1, 6'h0C, 32'hFACE_0FF0, 4'hF);
    xact(1'b0, 6'h0C, '0, '0);

    xact(1'b1, 6'h10, 32'hA1A1_0000, 4'hF);
    xact(1'b0, 6'h10, '0, '0);
    xact(1'b0, 6'h14, '0, '0);
    xact(1'b1, 6'h14, 32'h0000_B2B2, 4'hF);
    xact(1'b0, 6'h10, '0, '0);
    xact(1'b0, 6'h14, '0, '0);

    for (int s = 0; s < 15; s++) begin
      xact(1'b1, 6'h00, 32'h0BAD_0000 + 32'(s), 4'(s));
      xact(1'b1, 6'h10, 32'h0BAD_1000 + 32'(s), 4'(s));
      xact(1'b1, 6'h14, 32'h0BAD_2000 + 32'(s), 4'(s));
      xact(1'b1, 6'h08, 32'h0BAD_3000 + 32'(s), 4'(s));
      xact(1'b1, 6'h0C, 32'h0BAD_4000 + 32'(s), 4'(s));
    end

    for (int a = 32; a < 64; a += 4) xact(1'b1, 6'(a), 32'h7777_0000 + 32'(a), 4'hF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule